// File: doc/BRIEF.md
# Level-1 Accept Burst Generator

This block emits a programmed burst of single-cycle level-1 accept pulses. Software writes one 16-bit control word. The upper byte sets the number of idle clock cycles between pulses, and the lower byte sets how many pulses to send. The burst starts on the clock cycle after the write. A busy flag stays high for the whole burst, and any control write that arrives during that time is dropped.

The block also keeps a running count of accepts. The count includes accepts that arrive on an input pin and the pulses the block generates itself. It is read back as two words: a low word that holds count bits [15:0], and a high word that holds the upper count bits in its low byte with zeros above them. A command strobe carries two action bits. One bit clears the accept count. The other bit sends a one-cycle clear pulse to a beam-crossing counter that sits elsewhere.

No port streams data, so every pin is a plain level or strobe and no valid/ready handshake is needed. Strobes are sampled on the rising clock edge. All outputs come from registers and change only on that edge.

Top module: `l1a_burst_gen`

## Requirements
- R1: While reset is held and after it is released, `l1a_o`, `busy_o` and `bx_clr_o` are 0 and both count readback words are 0.
- R2: A control write taken while idle produces the first pulse on `l1a_o` in the cycle right after the write cycle.
- R3: Control bits [7:0] = N with 1 ≤ N ≤ 255 produce exactly N pulses. N = 0 produces exactly one pulse. Each pulse lasts one cycle.
- R4: Control bits [15:8] = G put exactly G low cycles on `l1a_o` between two pulses of the same burst. G = 0 gives back-to-back pulses.
- R5: `busy_o` is high from the first pulse through the last pulse of a burst, and goes low in the cycle after the last pulse.
- R6: A control write made while `busy_o` is high is ignored: the running burst keeps its timing and count, and no extra burst follows it. A write made in the first cycle with `busy_o` low is accepted.
- R7: The count rises by one for every cycle in which `l1a_o` or `acc_in` is high. A cycle with both high counts once. The new value is visible in the following cycle.
- R8: `cnt_lo_o` equals count bits [15:0]. `cnt_hi_o` holds count bits [ACC_W-1:16] in its low bits, and all of its bits above those are 0.
- R9: The count wraps from all ones (0xFFFFFF at the default width) to 0.
- R10: `cmd_wr` with `cmd_evn_clr` high makes the count 0 in the next cycle, even if an increment happens in the same cycle.
- R11: `cmd_wr` with `cmd_bx_clr` high gives exactly one high cycle on `bx_clr_o`, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 16 | Control word: [15:8] gap, [7:0] pulse count |
| cmd_wr | input | 1 | Command strobe |
| cmd_evn_clr | input | 1 | With `cmd_wr`: clear the accept count |
| cmd_bx_clr | input | 1 | With `cmd_wr`: request a beam-crossing clear pulse |
| acc_in | input | 1 | Externally received accept, one per high cycle |
| l1a_o | output | 1 | Generated accept pulse |
| busy_o | output | 1 | Burst in progress |
| bx_clr_o | output | 1 | One-cycle beam-crossing clear pulse |
| cnt_lo_o | output | 16 | Accept count bits [15:0] |
| cnt_hi_o | output | 16 | Upper accept count bits, zero-extended |

## Verification
The assertions assume that reset is applied before the first strobe and that every input changes only between clock edges. They assume nothing about how control writes and busy periods line up, because dropping a write during a burst is itself a checked behaviour. The stimulus drives every input on the falling edge. It deliberately holds `ctl_wr` high across whole bursts and overlaps `acc_in` with generated pulses and with clears, so the reference model sees every ordering the assertions accept. The bench builds the counter 17 bits wide so that the wrap can be reached inside the run.

// File: rtl/l1a_burst_pkg.sv
`timescale 1ns/1ps
package l1a_burst_pkg;
  // Sequencer phases: idle, pulse cycle, idle gap between pulses
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/l1a_gap_timer.sv
`timescale 1ns/1ps
module l1a_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [GAP_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (load)
      remain_q <= load_val;
    else if (run && (remain_q != '0))
      remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

  // R4: a running timer steps down by one each cycle
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !expired) |=> (remain_q == $past(remain_q) - 1'b1));

  // R4: an idle timer holds its value
  a_r4_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(remain_q));
endmodule

// File: rtl/l1a_burst_seq.sv
`timescale 1ns/1ps
module l1a_burst_seq
  import l1a_burst_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [GAP_W-1:0] start_gap,
  output logic             pulse_o,
  output logic             busy_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] rem_q;   // pulses still due after the current one
  logic [GAP_W-1:0] gap_q;
  logic             tmr_load;
  logic             tmr_run;
  logic             tmr_done;

  assign tmr_load = (state_q == SEQ_PULSE) && (rem_q != '0) && (gap_q != '0);
  assign tmr_run  = (state_q == SEQ_GAP);

  l1a_gap_timer #(.GAP_W(GAP_W)) gap_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (gap_q - 1'b1),
    .run      (tmr_run),
    .expired  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_PULSE;
          rem_q   <= (start_cnt == '0) ? '0 : start_cnt - 1'b1;
          gap_q   <= start_gap;
        end
        SEQ_PULSE: begin
          if (rem_q == '0) begin
            state_q <= SEQ_IDLE;
          end else if (gap_q == '0) begin
            rem_q <= rem_q - 1'b1;
          end else begin
            state_q <= SEQ_GAP;
          end
        end
        SEQ_GAP: if (tmr_done) begin
          state_q <= SEQ_PULSE;
          rem_q   <= rem_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign pulse_o = (state_q == SEQ_PULSE);
  assign busy_o  = (state_q != SEQ_IDLE);

  // R5: a burst opens with a pulse
  a_r5_opens_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> pulse_o);

  // R5: busy drops only right after a pulse
  a_r5_closes_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(pulse_o));

  // R6: a write during a burst leaves the programmed gap untouched
  a_r6_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start) |=> (gap_q == $past(gap_q)));

  // R3: pulses still owed keep the burst alive
  a_r3_owed_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && (rem_q != '0)) |=> busy_o);
endmodule

// File: rtl/l1a_accept_ctr.sv
`timescale 1ns/1ps
module l1a_accept_ctr #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ACC_W-1:0] cnt_o
);
  logic [ACC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr)
      cnt_q <= '0;
    else if (inc)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R10: clear wins over an increment in the same cycle
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R7: one step per counted cycle
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: no event, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));

  // R9: all ones rolls over to zero
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/l1a_burst_gen.sv
`timescale 1ns/1ps
module l1a_burst_gen #(
  parameter int CNT_W = 8,
  parameter int GAP_W = 8,
  parameter int ACC_W = 24,
  parameter int LO_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_wr,
  input  logic [CNT_W+GAP_W-1:0] ctl_data,
  input  logic                   cmd_wr,
  input  logic                   cmd_evn_clr,
  input  logic                   cmd_bx_clr,
  input  logic                   acc_in,
  output logic                   l1a_o,
  output logic                   busy_o,
  output logic                   bx_clr_o,
  output logic [LO_W-1:0]        cnt_lo_o,
  output logic [LO_W-1:0]        cnt_hi_o
);
  localparam int CTL_W = CNT_W + GAP_W;
  localparam int HI_W  = ACC_W - LO_W;

  logic             pulse;
  logic [ACC_W-1:0] acc_cnt;
  logic             bx_q;

  l1a_burst_seq #(.CNT_W(CNT_W), .GAP_W(GAP_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ctl_wr),
    .start_cnt (ctl_data[CNT_W-1:0]),
    .start_gap (ctl_data[CTL_W-1:CNT_W]),
    .pulse_o   (pulse),
    .busy_o    (busy_o)
  );

  l1a_accept_ctr #(.ACC_W(ACC_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd_wr && cmd_evn_clr),
    .inc   (pulse || acc_in),
    .cnt_o (acc_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bx_q <= 1'b0;
    else
      bx_q <= cmd_wr && cmd_bx_clr;
  end

  assign l1a_o    = pulse;
  assign bx_clr_o = bx_q;
  assign cnt_lo_o = acc_cnt[LO_W-1:0];
  assign cnt_hi_o = {{(LO_W-HI_W){1'b0}}, acc_cnt[ACC_W-1:LO_W]};

  // R11: a bx clear request yields the pulse in the following cycle
  a_r11_bx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bx_clr) |=> bx_clr_o);

  // R11: the pulse lasts one cycle unless requested again
  a_r11_bx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_clr_o && !(cmd_wr && cmd_bx_clr)) |=> !bx_clr_o);

  // R7: a generated pulse moves the low count word unless cleared
  a_r7_pulse_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a_o && !(cmd_wr && cmd_evn_clr)) |=> (cnt_lo_o == $past(cnt_lo_o) + 1'b1));
endmodule

// File: tb/l1a_burst_gen_tb.sv
`timescale 1ns/1ps
module l1a_burst_gen_tb_top;
  localparam int ACC_W = 17;
  localparam int LO_W  = 16;
  localparam int MOD   = 1 << ACC_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_data = '0;
  logic        cmd_wr = 1'b0;
  logic        cmd_evn_clr = 1'b0;
  logic        cmd_bx_clr = 1'b0;
  logic        acc_in = 1'b0;
  logic        l1a_o, busy_o, bx_clr_o;
  logic [15:0] cnt_lo_o, cnt_hi_o;

  always #10 clk = ~clk;

  l1a_burst_gen #(.ACC_W(ACC_W), .LO_W(LO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .cmd_wr(cmd_wr), .cmd_evn_clr(cmd_evn_clr), .cmd_bx_clr(cmd_bx_clr),
    .acc_in(acc_in), .l1a_o(l1a_o), .busy_o(busy_o), .bx_clr_o(bx_clr_o),
    .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o)
  );

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 0;
  string tag     = "R1";

  // Behavioural reference: burst as an arithmetic schedule of pulse cycles
  int cyc = 0;
  int first_p = -1, last_p = -2, per_p = 1;
  int m_cnt = 0;
  bit m_bx = 0;

  function automatic bit m_busy(int c);
    return (c >= first_p) && (c <= last_p);
  endfunction

  function automatic bit m_pulse(int c);
    return m_busy(c) && (((c - first_p) % per_p) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      first_p = -1; last_p = -2; per_p = 1; m_cnt = 0; m_bx = 0;
    end else begin
      if (cmd_wr && cmd_evn_clr) m_cnt = 0;
      else if (m_pulse(cyc) || acc_in) m_cnt = (m_cnt + 1) % MOD;
      m_bx = cmd_wr && cmd_bx_clr;
      if (ctl_wr && !m_busy(cyc)) begin
        int n;
        n = (ctl_data[7:0] == 0) ? 1 : int'(ctl_data[7:0]);
        per_p   = int'(ctl_data[15:8]) + 1;
        first_p = cyc + 1;
        last_p  = first_p + (n - 1) * per_p;
      end
    end
    cyc = cyc + 1;
  end

  task automatic chk(string t, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "l1a_o (R3)", int'(l1a_o), int'(m_pulse(cyc)));
      chk(tag, "busy_o (R5)", int'(busy_o), int'(m_busy(cyc)));
      chk(tag, "cnt_lo_o (R7)", int'(cnt_lo_o), m_cnt % 65536);
      chk(tag, "cnt_hi_o (R8)", int'(cnt_hi_o), m_cnt / 65536);
      chk(tag, "bx_clr_o (R11)", int'(bx_clr_o), int'(m_bx));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(int cnt, int gap);
    ctl_data = {gap[7:0], cnt[7:0]};
    ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    tick(3);
    chk("R1", "l1a_o in reset", int'(l1a_o), 0);
    chk("R1", "busy_o in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "cnt_lo_o", int'(cnt_lo_o), 0);
    chk("R1", "cnt_hi_o", int'(cnt_hi_o), 0);
    chk("R1", "bx_clr_o", int'(bx_clr_o), 0);

    // R2: first pulse one cycle after the write
    tag = "R2";
    wr_ctl(3, 2);
    chk("R2", "first pulse", int'(l1a_o), 1);
    tick(12);

    // R3: count 0 still sends one pulse
    tag = "R3";
    wr_ctl(0, 5);
    tick(10);

    // R4: back-to-back and wide gaps
    tag = "R4";
    wr_ctl(4, 0);
    tick(8);
    wr_ctl(3, 7);
    tick(25);
    wr_ctl(2, 1);
    tick(6);

    // R6: writes during a burst are dropped, the first idle write is taken
    tag = "R6";
    wr_ctl(5, 3);
    wr_ctl(1, 0);
    tick(3);
    wr_ctl(9, 9);
    tick(20);
    ctl_data = {8'd2, 8'd3};
    ctl_wr = 1'b1;
    tick(30);
    ctl_wr = 1'b0;
    tick(12);

    // R7: external accepts overlapping generated pulses
    tag = "R7";
    wr_ctl(6, 1);
    for (int i = 0; i < 20; i++) begin
      acc_in = (i % 3) != 0;
      tick(1);
    end
    acc_in = 1'b0;
    tick(5);

    // R10 and R11: clear against a simultaneous increment, bx pulse
    tag = "R10";
    acc_in = 1'b1;
    cmd_wr = 1'b1; cmd_evn_clr = 1'b1; cmd_bx_clr = 1'b1;
    tick(1);
    cmd_wr = 1'b0; cmd_evn_clr = 1'b0; cmd_bx_clr = 1'b0;
    chk("R10", "count after clear", int'(cnt_lo_o), 0);
    chk("R11", "bx pulse", int'(bx_clr_o), 1);
    tick(1);
    chk("R11", "bx pulse ends", int'(bx_clr_o), 0);
    acc_in = 1'b0;
    tag = "R11";
    cmd_wr = 1'b1; cmd_bx_clr = 1'b1; cmd_evn_clr = 1'b0;
    tick(1);
    cmd_wr = 1'b0; cmd_bx_clr = 1'b0;
    tick(3);

    // R3: largest count
    tag = "R3";
    wr_ctl(255, 0);
    tick(260);

    // R9 and R8: wrap of the narrowed counter through the high word
    tag = "R9";
    cmd_wr = 1'b1; cmd_evn_clr = 1'b1;
    tick(1);
    cmd_wr = 1'b0; cmd_evn_clr = 1'b0;
    acc_in = 1'b1;
    tick(MOD - 1);
    chk("R8", "high word at all ones", int'(cnt_hi_o), 1);
    chk("R8", "low word at all ones", int'(cnt_lo_o), 16'hFFFF);
    tick(1);
    acc_in = 1'b0;
    chk("R9", "low word after wrap", int'(cnt_lo_o), 0);
    chk("R9", "high word after wrap", int'(cnt_hi_o), 0);
    tick(3);

    done = 1;
    summary();
    $finish;
  end
endmodule